// File: doc/BRIEF.md
# Asynchronous 10-bit Serial Transmitter

This block is the sending side of a full-duplex asynchronous serial port. Each frame holds ten bits on one output line: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Bit timing comes from a free-running divide-by-16 counter that advances once per pulse of an external baud tick. One bit period is therefore one full cycle of that counter.

Software loads a byte through a one-cycle write strobe. The transmitter does not start at once. It waits for the next rollover of the divide-by-16 counter and drives the start bit a fixed five system cycles after that rollover. Every later bit boundary keeps the same five-cycle offset from its own rollover. A sticky completion flag rises two cycles after the stop bit reaches the line and stays high until software clears it. A write that arrives while a byte is waiting or being sent is dropped.

Top module: `serial_tx10`

## Requirements
- R1: After reset and between frames the output line `txd` is 1 and `tx_done` is 0 until a frame completes.
- R2: A frame on `txd` is a start bit of 0, then `wr_data[0]` through `wr_data[7]` in that order, then a stop bit of 1.
- R3: Each bit stays on `txd` for exactly one divide-by-16 period (16 baud ticks), and `txd` changes only 5 cycles after a counter rollover.
- R4: The start bit appears on `txd` 5 system cycles after the first counter rollover that occurs in a cycle later than the accepted write. A rollover in the same cycle as the write does not count.
- R5: `tx_done` rises exactly 2 system cycles after the stop bit first appears on `txd`.
- R6: `tx_done` stays 1 until `done_clr` is high in a cycle, and it falls in the next cycle. If the flag is being set in the same cycle as a clear, the set wins.
- R7: A write while a byte is waiting or being sent has no effect on the frame data or its timing. A write is accepted again from the first cycle after the stop bit period ends.
- R8: The divide-by-16 counter starts at 0 at reset, advances only in cycles with `baud_tick` high, and is never restarted by a write. Frame timing follows this counter for any spacing of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse that advances the divide-by-16 counter |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| done_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial output line, idles high |
| tx_done | output | 1 | Sticky transmit-complete flag |

## Verification
The bench places a write in the same cycle as a counter rollover. A design that counted that rollover would start the frame one bit period early. It also sends bytes with the ticks spread out, which exposes any design that restarts the divider on a write or counts system cycles instead of ticks. It issues writes during the wait and send phases, where a leaky design would corrupt the byte or shift its timing. It also raises a clear in the same cycle as the completion flag is set, where a design with the wrong priority loses the flag.

// File: rtl/serial_tx10_pkg.sv
package serial_tx10_pkg;
    localparam int DATA_W = 8;
    localparam int POS_W  = $clog2(DATA_W + 2);
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_WAIT,
        TX_SEND
    } tx_phase_e;

    typedef struct packed {
        tx_phase_e         phase;
        logic [POS_W-1:0]  pos;
        logic [DATA_W-1:0] data;
        logic              line;
        logic              done;
    } tx_regs_t;
endpackage

// File: rtl/serial_tx10_div.sv
module serial_tx10_div #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic roll
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        roll  = tick && (cnt_q == CW'(DIV - 1));
        if (tick) begin
            cnt_d = roll ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/serial_tx10_dly.sv
module serial_tx10_dly #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] sr_q, sr_d;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb sr_d = din;
        end else begin : g_chain
            always_comb sr_d = {sr_q[DEPTH-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[DEPTH-1];
endmodule

// File: rtl/serial_tx10.sv
module serial_tx10
    import serial_tx10_pkg::*;
#(
    parameter int DIV       = 16,
    parameter int START_DLY = 5,
    parameter int DONE_DLY  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done_clr,
    output logic              txd,
    output logic              tx_done
);
    localparam int LAG = START_DLY - 1;

    tx_regs_t r_q, r_d;
    logic     roll;
    logic     fire;
    logic     busy;
    logic     stop_put;
    logic     done_set;

    assign busy = (r_q.phase != TX_IDLE);

    serial_tx10_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (baud_tick),
        .roll  (roll)
    );

    serial_tx10_dly #(.DEPTH(LAG)) u_lag (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (roll & busy),
        .dout  (fire)
    );

    serial_tx10_dly #(.DEPTH(DONE_DLY)) u_done (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (stop_put),
        .dout  (done_set)
    );

    always_comb begin
        r_d      = r_q;
        stop_put = 1'b0;

        if (r_q.phase == TX_IDLE && wr_en) begin
            r_d.phase = TX_WAIT;
            r_d.data  = wr_data;
        end

        if (fire) begin
            case (r_q.phase)
                TX_WAIT: begin
                    r_d.phase = TX_SEND;
                    r_d.pos   = '0;
                    r_d.line  = 1'b0;
                end
                TX_SEND: begin
                    if (r_q.pos == POS_W'(DATA_W + 1)) begin
                        r_d.phase = TX_IDLE;
                        r_d.pos   = '0;
                        r_d.line  = 1'b1;
                    end else if (r_q.pos == POS_W'(DATA_W)) begin
                        r_d.pos   = r_q.pos + 1'b1;
                        r_d.line  = 1'b1;
                        stop_put  = 1'b1;
                    end else begin
                        r_d.pos   = r_q.pos + 1'b1;
                        r_d.line  = r_q.data[r_q.pos[IDX_W-1:0]];
                    end
                end
                default: ;
            endcase
        end

        r_d.done = done_set | (r_q.done & ~done_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase <= TX_IDLE;
            r_q.pos   <= '0;
            r_q.data  <= '0;
            r_q.line  <= 1'b1;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign txd     = r_q.line;
    assign tx_done = r_q.done;
endmodule

// File: rtl/serial_tx10_chk.sv
module serial_tx10_chk #(
    parameter int LAG = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic       tx_done,
    input logic       done_clr,
    input logic       busy,
    input logic       roll,
    input logic       fire,
    input logic [7:0] held
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R1

    AST_EDGE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(fire)); // R3

    AST_FIRE_FROM_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(roll, LAG)); // R4

    AST_DONE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> ($past(busy, 2) && $past(txd, 2))); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !done_clr) |=> tx_done); // R6

    AST_BYTE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(held)); // R7
endmodule

bind serial_tx10 serial_tx10_chk #(.LAG(START_DLY - 1)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd      (txd),
    .tx_done  (tx_done),
    .done_clr (done_clr),
    .busy     (busy),
    .roll     (roll),
    .fire     (fire),
    .held     (r_q.data)
);

// File: tb/test_serial_tx10.sv
`timescale 1ns/100ps
module test_serial_tx10;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       done_clr = 1'b0;
    logic       txd;
    logic       tx_done;

    always #2.5 clk = ~clk;

    serial_tx10 i_serial_tx10 (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .done_clr  (done_clr),
        .txd       (txd),
        .tx_done   (tx_done)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // behavioural reference
    int n, mcnt, mst, mk, done_at, gap, ph;
    bit m_txd, m_prev, m_done, m_ign;
    logic [7:0] mdata;
    int evq[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, n, act, exp);
        end
    endtask

    function automatic string tx_tag();
        if (m_ign && mst != 0) return "R7";
        if (mst == 1) return (gap > 1) ? "R8" : "R4";
        if (mst == 2) begin
            if (mk == 0) return "R4";
            if (txd === m_prev) return "R3";
            return "R2";
        end
        return "R1";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; baud_tick = 0; wr_en = 0; done_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0; mcnt = 0; mst = 0; mk = -1; done_at = -100; ph = 0;
        m_txd = 1; m_prev = 1; m_done = 0; m_ign = 0; mdata = 0;
        evq.delete();
    endtask

    task automatic cyc(input bit w, input logic [7:0] d, input bit c);
        bit tk, roll, acc;
        @(negedge clk);
        check(txd === m_txd, tx_tag(), int'(txd), int'(m_txd), "txd");
        check(tx_done === m_done, (n >= done_at - 1 && n <= done_at) ? "R5" : "R6",
              int'(tx_done), int'(m_done), "tx_done");
        tk = ((ph % gap) == 0);
        ph++;
        baud_tick = tk; wr_en = w; wr_data = d; done_clr = c;
        roll = tk && (mcnt == 15);
        if (tk) mcnt = (mcnt + 1) % 16;
        acc = w && (mst == 0);
        if (w && mst != 0) m_ign = 1;
        if (roll && mst != 0) evq.push_back(n + 5);
        if (evq.size() > 0 && evq[0] == n + 1) begin
            void'(evq.pop_front());
            m_prev = m_txd;
            mk++;
            if (mk == 0) begin
                mst = 2; m_txd = 0;
            end else if (mk <= 8) begin
                m_txd = mdata[mk-1];
            end else if (mk == 9) begin
                m_txd = 1; done_at = n + 3;
            end else begin
                mst = 0; m_txd = 1; mk = -1;
            end
        end
        if (n + 1 == done_at) m_done = 1;
        else if (c) m_done = 0;
        if (acc) begin
            mst = 1; mdata = d; m_ign = 0;
        end
        n++;
    endtask

    task automatic run_frame(input logic [7:0] d, input bit poke, input bit clr_on_set);
        cyc(1, d, 0);
        while (mst != 0) begin
            cyc(poke && (n % 37 == 0), 8'hFF, clr_on_set && (done_at == n + 1));
        end
    endtask

    initial begin
        gap = 1;
        do_reset();
        // R1: reset state
        @(negedge clk);
        check(txd === 1'b1, "R1", int'(txd), 1, "txd after reset");
        check(tx_done === 1'b0, "R1", int'(tx_done), 0, "tx_done after reset");
        repeat (5) cyc(0, 0, 0);

        // R2 R3 R5: plain frame, tick every cycle
        run_frame(8'hA5, 0, 0);
        repeat (10) cyc(0, 0, 0);
        cyc(0, 0, 1); // R6 clear
        repeat (4) cyc(0, 0, 0);

        // R7 R8 R6: sparse ticks, writes during frame, clear in set cycle
        gap = 2;
        run_frame(8'h3C, 1, 1);
        repeat (20) cyc(0, 0, 0);
        cyc(0, 0, 1);

        // R4: write in the same cycle as a rollover, then a write while waiting
        gap = 1;
        while (mcnt != 15) cyc(0, 0, 0);
        cyc(1, 8'h96, 0);
        cyc(1, 8'h0F, 0);
        while (mst != 0) cyc(0, 0, 0);

        // R7: back-to-back write on the first idle cycle, slow ticks
        gap = 3;
        run_frame(8'h81, 0, 0);
        run_frame(8'h00, 1, 0);
        cyc(0, 0, 1);
        gap = 1;
        run_frame(8'hFF, 0, 0);
        repeat (8) cyc(0, 0, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule